// File: doc/BRIEF.md
# Clock-Enable Control Slave on a Two-Wire Bus

This block is a two-wire (I2C) slave. It keeps a small bank of 8-bit control bytes, and each bit of each byte turns one clock output on or off. The block runs on a fast system clock. It resynchronises the SCL and SDA inputs and detects their edges on that clock. It pulls SDA low through an open-drain enable.

The bus has no register pointer. A write carries the device address, then a command byte, then a byte-count byte, and then the data. The command and byte-count bytes are acknowledged and thrown away. The data fills the bank starting at byte 0. A read streams out the bank size first and then every control byte in ascending order.

A power-down input makes the slave ignore the bus completely while the bank keeps its contents. A transfer to any other address leaves the bank untouched.

Top module: `clkctl_i2c_top`

## Requirements
- R1: After reset every control byte holds 0xFF (all clock outputs enabled) and `sda_oe` is 0.
- R2: The slave acknowledges (pulls SDA low in the ninth clock) only the address byte 0xD2, which selects write, and 0xD3, which selects read. Bit 0 of the address byte gives the direction, 0 meaning write. Any other address is not acknowledged, and the rest of that transfer leaves the bank unchanged.
- R3: In a write, the two bytes after the address are acknowledged and their values discarded. Data byte k after them lands in control byte k, where control byte k is `clk_en[8k+7:8k]`, and bytes are received MSB first.
- R4: A data byte takes effect at the end of its acknowledge clock, before any stop. A write that is ended early changes only the bytes already sent.
- R5: At most 10 bytes following the address are acknowledged in one write. The byte after that limit gets no acknowledge and does not alter the bank.
- R6: A read returns the value 8 (the bank size) first and then control bytes 0 to 7, each MSB first. The slave moves on to the next byte each time the master acknowledges.
- R7: When the master does not acknowledge a read byte, the slave releases SDA and keeps it released, so the line reads all ones, until the next start.
- R8: A repeated start sends the slave back to address reception. A read that follows in the same transfer returns the values just written.
- R9: While `pwrdn` is 1 the slave acknowledges nothing, drives SDA never, and the bank keeps its values. Normal operation resumes once `pwrdn` is 0.
- R10: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| pwrdn | input | 1 | Power-down: bus ignored, bank retained |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| clk_en | output | NUM_REGS*8 | Control bank; byte k in bits [8k+7:8k] |

## Verification
The bench uses the default parameters: 8 control bytes, a 10-byte limit, device address 0x69 and two synchroniser stages. With these values the end of the bank and the transfer limit fall on the same byte. A single over-long write therefore tests both the last-register store and the refusal of the eleventh byte. The two-stage synchroniser keeps the SDA response three system clocks after each SCL edge, well inside the quarter-bit spacing that the bench's bus model uses.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_RX,
        ST_DACK,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } link_st_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    // bytes after the address that are acknowledged but not stored
    localparam int SKIP_BYTES = 2;
    localparam logic [7:0] RELEASED_BYTE = 8'hFF;

    function automatic logic addr_hit(input logic [7:0] b, input logic [6:0] dev);
        return b[7:1] == dev;
    endfunction

endpackage

// File: rtl/clkctl_bus_sync.sv
module clkctl_bus_sync
    import clkctl_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] scl_q;
    logic [DEPTH-1:0] sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[DEPTH-2:0], scl_i};
            sda_q <= {sda_q[DEPTH-2:0], sda_i};
        end
    end

    logic scl_now, scl_prev, sda_now, sda_prev;
    assign scl_now  = scl_q[STAGES-1];
    assign scl_prev = scl_q[STAGES];
    assign sda_now  = sda_q[STAGES-1];
    assign sda_prev = sda_q[STAGES];

    always_comb begin
        ev.scl      = scl_now;
        ev.sda      = sda_now;
        ev.scl_rise = scl_now & ~scl_prev;
        ev.scl_fall = ~scl_now & scl_prev;
        ev.start    = scl_now & scl_prev & sda_prev & ~sda_now;
        ev.stop     = scl_now & scl_prev & ~sda_prev & sda_now;
    end

endmodule

// File: rtl/clkctl_regs.sv
module clkctl_regs
    import clkctl_pkg::*;
#(
    parameter int         NUM_REGS  = 8,
    parameter int         IDX_W     = 4,
    parameter logic [7:0] RESET_VAL = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [7:0]            wr_data,
    output logic [NUM_REGS*8-1:0] bank
);

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                bank[g*8 +: 8] <= RESET_VAL;
            else if (wr_en && wr_idx == IDX_W'(g))
                bank[g*8 +: 8] <= wr_data;
        end
    end

    // R3
    wr_idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> int'(wr_idx) < NUM_REGS);

    // R4
    bank_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> bank == $past(bank));

endmodule

// File: rtl/clkctl_link.sv
module clkctl_link
    import clkctl_pkg::*;
#(
    parameter int         NUM_REGS  = 8,
    parameter int         MAX_BYTES = 10,
    parameter logic [6:0] DEV_ADDR  = 7'h69,
    parameter int         IDX_W     = 4,
    parameter int         CNT_W     = 5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwrdn,
    input  bus_ev_t               ev,
    input  logic [NUM_REGS*8-1:0] bank,
    output logic                  sda_oe,
    output logic                  wr_en,
    output logic [IDX_W-1:0]      wr_idx,
    output logic [7:0]            wr_data
);
    localparam int STORE_END = SKIP_BYTES + NUM_REGS;

    link_st_e         st;
    logic [3:0]       bitcnt;
    logic [7:0]       shift;
    logic [CNT_W-1:0] idx;
    logic             rd_mode;
    logic             mack_ok;

    logic             rx_accept;
    logic [7:0]       tx_pick;
    int               pick_n;
    logic [CNT_W-1:0] idx_inc;

    assign rx_accept = (int'(idx) < MAX_BYTES) && (int'(idx) < STORE_END);
    assign idx_inc   = (int'(idx) < MAX_BYTES) ? idx + CNT_W'(1) : idx;

    always_comb begin
        pick_n  = (st == ST_AACK) ? 0 : int'(idx) + 1;
        tx_pick = RELEASED_BYTE;
        if (pick_n == 0) begin
            tx_pick = 8'(NUM_REGS);
        end else if (pick_n < MAX_BYTES) begin
            for (int k = 0; k < NUM_REGS; k++)
                if (pick_n == k + 1) tx_pick = bank[k*8 +: 8];
        end
    end

    always_comb begin
        case (st)
            ST_AACK, ST_DACK: sda_oe = 1'b1;
            ST_TX:            sda_oe = ~shift[7];
            default:          sda_oe = 1'b0;
        endcase
    end

    assign wr_en   = (st == ST_DACK) && ev.scl_fall && !pwrdn && !ev.start && !ev.stop
                     && (int'(idx) >= SKIP_BYTES);
    assign wr_idx  = IDX_W'(int'(idx) - SKIP_BYTES);
    assign wr_data = shift;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bitcnt  <= '0;
            shift   <= '0;
            idx     <= '0;
            rd_mode <= 1'b0;
            mack_ok <= 1'b0;
        end else if (pwrdn) begin
            st <= ST_IDLE;
        end else if (ev.start) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
        end else if (ev.stop) begin
            st <= ST_IDLE;
        end else begin
            case (st)
                ST_ADDR, ST_RX: begin
                    if (ev.scl_rise && bitcnt < 4'd8) begin
                        shift  <= {shift[6:0], ev.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (ev.scl_fall && bitcnt == 4'd8) begin
                        if (st == ST_ADDR) begin
                            if (addr_hit(shift, DEV_ADDR)) begin
                                st      <= ST_AACK;
                                rd_mode <= shift[0];
                                idx     <= '0;
                            end else begin
                                st <= ST_IGNORE;
                            end
                        end else begin
                            st <= rx_accept ? ST_DACK : ST_IGNORE;
                        end
                    end
                end
                ST_AACK: begin
                    if (ev.scl_fall) begin
                        bitcnt <= '0;
                        if (rd_mode) begin
                            st    <= ST_TX;
                            shift <= tx_pick;
                        end else begin
                            st <= ST_RX;
                        end
                    end
                end
                ST_DACK: begin
                    if (ev.scl_fall) begin
                        st     <= ST_RX;
                        bitcnt <= '0;
                        idx    <= idx_inc;
                    end
                end
                ST_TX: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            st <= ST_MACK;
                        end else begin
                            shift  <= {shift[6:0], 1'b1};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack_ok <= !ev.sda;
                    end else if (ev.scl_fall) begin
                        if (mack_ok) begin
                            st     <= ST_TX;
                            shift  <= tx_pick;
                            bitcnt <= '0;
                            idx    <= idx_inc;
                        end else begin
                            st <= ST_IGNORE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) && !$past(pwrdn) |-> !$past(ev.scl));

    // R8
    restart_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (ev.start && !pwrdn) |=> (st == ST_ADDR) && (bitcnt == 4'd0));

    // R5
    store_limit_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> int'(idx) < MAX_BYTES);

endmodule

// File: rtl/clkctl_i2c_top.sv
module clkctl_i2c_top
    import clkctl_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter int         MAX_BYTES   = 10,
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter logic [7:0] RESET_VAL   = 8'hFF,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwrdn,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] clk_en
);
    localparam int IDX_W = $clog2(NUM_REGS + 1);
    localparam int CNT_W = $clog2(MAX_BYTES + NUM_REGS + 2);

    bus_ev_t          ev;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data;

    clkctl_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    clkctl_link #(
        .NUM_REGS  (NUM_REGS),
        .MAX_BYTES (MAX_BYTES),
        .DEV_ADDR  (DEV_ADDR),
        .IDX_W     (IDX_W),
        .CNT_W     (CNT_W)
    ) u_link (
        .clk     (clk),
        .rst     (rst),
        .pwrdn   (pwrdn),
        .ev      (ev),
        .bank    (clk_en),
        .sda_oe  (sda_oe),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    clkctl_regs #(
        .NUM_REGS  (NUM_REGS),
        .IDX_W     (IDX_W),
        .RESET_VAL (RESET_VAL)
    ) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .bank    (clk_en)
    );

    // R9
    pwrdn_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        pwrdn |=> !sda_oe);

    // R9
    pwrdn_retain_chk: assert property (@(posedge clk) disable iff (rst)
        pwrdn |=> clk_en == $past(clk_en));

endmodule

// File: tb/tb_clkctl_i2c_top.sv
module tb_clkctl_i2c_top;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 10;
    localparam int NREG       = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwrdn = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] clk_en;

    int total = 0;
    int bad = 0;
    int r10_viol = 0;
    logic [NREG*8-1:0] exp_bank;

    assign sda_line = !(m_low | sda_oe);

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl_i2c_top dut (
        .clk    (clk),
        .rst    (rst),
        .pwrdn  (pwrdn),
        .scl_i  (m_scl),
        .sda_i  (sda_line),
        .sda_oe (sda_oe),
        .clk_en (clk_en)
    );

    // R10 monitor: open-drain enable must not move while SCL is high
    logic prev_oe = 1'b0;
    always @(negedge clk) begin
        if (!rst && sda_oe != prev_oe && m_scl) r10_viol++;
        prev_oe <= sda_oe;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic quarter(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; quarter();
        m_scl = 1'b1; quarter(2);
        m_low = 1'b1; quarter(2);
        m_scl = 1'b0; quarter();
    endtask

    task automatic bus_stop();
        m_low = 1'b1; quarter();
        m_scl = 1'b1; quarter(2);
        m_low = 1'b0; quarter(2);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            quarter();
            m_low = !b[i];
            quarter();
            m_scl = 1'b1; quarter(2);
            m_scl = 1'b0;
        end
        quarter();
        m_low = 1'b0;
        quarter();
        m_scl = 1'b1; quarter();
        acked = !sda_line;
        quarter();
        m_scl = 1'b0;
        quarter();
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic give_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            quarter(2);
            m_scl = 1'b1; quarter();
            b[i] = sda_line;
            quarter();
            m_scl = 1'b0;
        end
        quarter();
        m_low = give_ack;
        quarter();
        m_scl = 1'b1; quarter(2);
        m_scl = 1'b0;
        quarter();
        m_low = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 bank reset", 64'(clk_en), {NREG{8'hFF}});
        check("R1 sda released", 64'(sda_oe), 64'd0);
    endtask

    task automatic t_write_full();
        logic a;
        bus_start();
        send_byte(8'hD2, a); check("R2 write address ack", 64'(a), 64'd1);
        send_byte(8'h5A, a); check("R3 command ack", 64'(a), 64'd1);
        send_byte(8'h33, a); check("R3 count ack", 64'(a), 64'd1);
        for (int k = 0; k < NREG; k++) begin
            send_byte(8'h10 + 8'(k * 17), a);
            exp_bank[k*8 +: 8] = 8'h10 + 8'(k * 17);
            check("R3 data ack", 64'(a), 64'd1);
        end
        send_byte(8'h00, a); check("R5 eleventh byte nack", 64'(a), 64'd0);
        bus_stop();
        check("R3 bank after full write", 64'(clk_en), 64'(exp_bank));
        check("R5 extra byte not stored", 64'(clk_en[7:0]), 64'h10);
    endtask

    task automatic t_partial();
        logic a;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        send_byte(8'hA5, a);
        exp_bank[7:0] = 8'hA5;
        check("R4 byte0 committed before stop", 64'(clk_en[7:0]), 64'hA5);
        check("R4 byte1 untouched", 64'(clk_en[15:8]), 64'(exp_bank[15:8]));
        bus_stop();
        check("R4 bank after short write", 64'(clk_en), 64'(exp_bank));
    endtask

    task automatic t_bad_addr();
        logic a;
        bus_start();
        send_byte(8'hA0, a); check("R2 foreign address nack", 64'(a), 64'd0);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a); check("R2 following byte nack", 64'(a), 64'd0);
        bus_stop();
        bus_start();
        send_byte(8'hD0, a); check("R2 neighbour address nack", 64'(a), 64'd0);
        send_byte(8'h00, a);
        bus_stop();
        check("R2 bank unchanged", 64'(clk_en), 64'(exp_bank));
    endtask

    task automatic t_read();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a); check("R2 read address ack", 64'(a), 64'd1);
        recv_byte(b, 1'b1); check("R6 byte count", 64'(b), 64'd8);
        for (int k = 0; k < NREG; k++) begin
            recv_byte(b, k != NREG - 1);
            check("R6 register readback", 64'(b), 64'(exp_bank[k*8 +: 8]));
        end
        bus_stop();
    endtask

    task automatic t_mnack();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD3, a);
        recv_byte(b, 1'b1);
        recv_byte(b, 1'b0); check("R6 first register", 64'(b), 64'(exp_bank[7:0]));
        recv_byte(b, 1'b1); check("R7 released after master nack", 64'(b), 64'hFF);
        bus_stop();
    endtask

    task automatic t_restart();
        logic a;
        logic [7:0] b;
        bus_start();
        send_byte(8'hD2, a);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h3C, a);
        exp_bank[7:0] = 8'h3C;
        bus_start();
        send_byte(8'hD3, a); check("R8 address after repeated start", 64'(a), 64'd1);
        recv_byte(b, 1'b1); check("R8 count after repeated start", 64'(b), 64'd8);
        recv_byte(b, 1'b0); check("R8 value just written", 64'(b), 64'h3C);
        bus_stop();
    endtask

    task automatic t_pwrdn();
        logic a;
        logic [7:0] b;
        pwrdn = 1'b1;
        quarter();
        bus_start();
        send_byte(8'hD2, a); check("R9 no ack in power-down", 64'(a), 64'd0);
        send_byte(8'h00, a);
        send_byte(8'h00, a);
        send_byte(8'h77, a);
        bus_stop();
        check("R9 bank retained", 64'(clk_en), 64'(exp_bank));
        pwrdn = 1'b0;
        quarter();
        bus_start();
        send_byte(8'hD3, a); check("R9 ack after power-up", 64'(a), 64'd1);
        recv_byte(b, 1'b1);
        recv_byte(b, 1'b0); check("R9 readback after power-up", 64'(b), 64'(exp_bank[7:0]));
        bus_stop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        exp_bank = {NREG{8'hFF}};
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_full();
        t_partial();
        t_bad_addr();
        t_read();
        t_mnack();
        t_restart();
        t_pwrdn();
        check("R10 oe moved with SCL high", 64'(r10_viol), 64'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule